// File: doc/BRIEF.md
# Complementary Mosaic Luminance and Chroma Separator

This block sits behind the digitizer of a camera front end whose sensor carries a complementary colour filter mosaic (yellow, cyan, magenta, green). The sensor has already summed two vertically adjacent filter sites into each sample. Along a line the samples therefore alternate between two kinds of pair-sum. Which two kinds they are depends on the line type. On one type a green-plus-cyan sum alternates with a magenta-plus-yellow sum. On the other type a magenta-plus-cyan sum alternates with a green-plus-yellow sum.

The block groups the valid samples of a line into horizontal pairs. For each pair it emits a luminance value equal to half the sum of the two samples. It also emits a colour-difference value equal to the later sample minus the earlier one. On the first line type that difference stands for R−Y. On the second it stands for −(B−Y). A flag travels with each result and names the kind of colour difference. The flag is derived from the line parity and the field identity, so the alternation stays correct in both interlaced fields. A line-start strobe realigns the pairing at every line.

Top module: `mosaic_yc_sep`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `y_o`, `c_o`, `ctype_o` and `res_vld_o` to zero at that edge.
- R2: For each pair of valid samples (first `a`, second `b`), `y_o` equals floor((a+b)/2) and has DW bits.
- R3: For each pair, `c_o` equals b−a as a signed two's complement value of DW+1 bits.
- R4: `ctype_o` equals `line_par_i` XOR `field_i`, captured on the line-start cycle and held for every result of that line. The value 0 marks R−Y and the value 1 marks −(B−Y).
- R5: Exactly one result is produced for every two valid samples of a line. Cycles with `pix_vld_i` low between samples do not affect the pairing.
- R6: `res_vld_o` pulses high for one cycle, two clock edges after the edge that captures the second sample of a pair.
- R7: A `line_start_i` pulse clears the pair phase, and an unpaired trailing sample of the previous line produces no result. A sample that arrives with `line_start_i` is taken as the first of a pair. No result appears two edges after a line-start cycle.
- R8: Between results, `y_o`, `c_o` and `ctype_o` keep the values of the last result.
- R9: At the value extremes, two full-scale samples give full-scale `y_o` and zero chroma. Zero followed by full scale gives chroma +(2^DW−1), and full scale followed by zero gives −(2^DW−1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_i | input | DW | Digitized pair-sum sample, unsigned |
| pix_vld_i | input | 1 | Sample on `pix_i` is valid this cycle |
| line_start_i | input | 1 | One-cycle strobe marking the start of a line |
| field_i | input | 1 | Field identity of the current line |
| line_par_i | input | 1 | Line parity within the field |
| y_o | output | DW | Luminance result |
| c_o | output | DW+1 | Colour-difference result, signed two's complement |
| ctype_o | output | 1 | 0: chroma is R−Y, 1: chroma is −(B−Y) |
| res_vld_o | output | 1 | New result on `y_o`, `c_o` and `ctype_o` this cycle |

## Verification
The properties check several rules on every cycle. Every result pulse is backed by a valid sample two edges earlier. No two result pulses are adjacent. No result follows a line start by two edges. The outputs hold between pulses. The chroma magnitude never exceeds twice the luminance plus one. The exact luminance and chroma values, the type flag for each combination of field and parity, the dropping of an odd trailing sample, and pairing across idle gaps can only be shown by the bench. It does this by comparing each result, and the cycle in which it appears, with a scoreboard entry computed from the samples it drove.

// File: rtl/yc_pkg.sv
// Shared types for the mosaic luminance/chroma separator.
package yc_pkg;
    // Kind of colour difference carried on the chroma output.
    typedef enum logic {
        CT_R_MINUS_Y  = 1'b0,
        CT_NEG_B_MINUS_Y = 1'b1
    } ctype_e;
endpackage

// File: rtl/yc_pair_phase.sv
// Groups valid samples of a line into horizontal pairs.
// Assumes line_start_i is a one-cycle strobe; a sample in the same cycle
// belongs to the new line and opens a pair. Emits one pair strobe per two
// valid samples, together with the line type latched at line start.
module yc_pair_phase
    import yc_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pix_i,
    input  logic          pix_vld_i,
    input  logic          line_start_i,
    input  logic          field_i,
    input  logic          line_par_i,
    output logic [DW-1:0] first_o,
    output logic [DW-1:0] second_o,
    output logic          pair_vld_o,
    output ctype_e        pair_type_o
);
    logic          have_first_q;
    logic [DW-1:0] hold_q;
    ctype_e        line_type_q;

    // Latch the line type at each line start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_type_q <= CT_R_MINUS_Y;
        end else if (line_start_i) begin
            line_type_q <= ctype_e'(line_par_i ^ field_i);
        end
    end

    // Track the pair phase and hold the first sample of an open pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_first_q <= 1'b0;
            hold_q       <= '0;
        end else if (line_start_i) begin
            have_first_q <= pix_vld_i;
            if (pix_vld_i) begin
                hold_q <= pix_i;
            end
        end else if (pix_vld_i) begin
            have_first_q <= !have_first_q;
            if (!have_first_q) begin
                hold_q <= pix_i;
            end
        end
    end

    // Present a completed pair to the arithmetic stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_o     <= '0;
            second_o    <= '0;
            pair_vld_o  <= 1'b0;
            pair_type_o <= CT_R_MINUS_Y;
        end else begin
            pair_vld_o <= pix_vld_i && have_first_q && !line_start_i;
            if (pix_vld_i && have_first_q && !line_start_i) begin
                first_o     <= hold_q;
                second_o    <= pix_i;
                pair_type_o <= line_type_q;
            end
        end
    end
endmodule

// File: rtl/yc_arith.sv
// Forms luminance (truncated half-sum) and chroma (second minus first)
// from one sample pair and registers them. Holds the outputs between pairs.
module yc_arith
    import yc_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] first_i,
    input  logic [DW-1:0] second_i,
    input  logic          pair_vld_i,
    input  ctype_e        pair_type_i,
    output logic [DW-1:0] y_o,
    output logic [DW:0]   c_o,
    output logic          ctype_o,
    output logic          res_vld_o
);
    localparam int SW = DW + 1;

    logic [SW-1:0]        sum_w;
    logic signed [SW-1:0] diff_w;

    // Combinational sum and difference of the pair.
    always_comb begin
        sum_w  = {1'b0, first_i} + {1'b0, second_i};
        diff_w = $signed({1'b0, second_i}) - $signed({1'b0, first_i});
    end

    // Register results on each pair; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_o       <= '0;
            c_o       <= '0;
            ctype_o   <= 1'b0;
            res_vld_o <= 1'b0;
        end else begin
            res_vld_o <= pair_vld_i;
            if (pair_vld_i) begin
                y_o     <= sum_w[SW-1:1];
                c_o     <= diff_w;
                ctype_o <= pair_type_i;
            end
        end
    end
endmodule

// File: rtl/mosaic_yc_sep.sv
// Top of the complementary-mosaic luminance/chroma separator.
// Assumes each input sample is an unsigned vertical pair-sum and that the
// line type is given by line parity XOR field identity. Latency is two
// clock edges from the second sample of a pair to the result.
module mosaic_yc_sep
    import yc_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pix_i,
    input  logic          pix_vld_i,
    input  logic          line_start_i,
    input  logic          field_i,
    input  logic          line_par_i,
    output logic [DW-1:0] y_o,
    output logic [DW:0]   c_o,
    output logic          ctype_o,
    output logic          res_vld_o
);
    logic [DW-1:0] first_w;
    logic [DW-1:0] second_w;
    logic          pair_vld_w;
    ctype_e        pair_type_w;

    yc_pair_phase #(.DW(DW)) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_i        (pix_i),
        .pix_vld_i    (pix_vld_i),
        .line_start_i (line_start_i),
        .field_i      (field_i),
        .line_par_i   (line_par_i),
        .first_o      (first_w),
        .second_o     (second_w),
        .pair_vld_o   (pair_vld_w),
        .pair_type_o  (pair_type_w)
    );

    yc_arith #(.DW(DW)) u_arith (
        .clk          (clk),
        .rst_n        (rst_n),
        .first_i      (first_w),
        .second_i     (second_w),
        .pair_vld_i   (pair_vld_w),
        .pair_type_i  (pair_type_w),
        .y_o          (y_o),
        .c_o          (c_o),
        .ctype_o      (ctype_o),
        .res_vld_o    (res_vld_o)
    );
endmodule

// File: rtl/yc_sep_chk.sv
// Property checker for mosaic_yc_sep, attached through bind.
module yc_sep_chk #(
    parameter int DW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_vld_i,
    input logic          line_start_i,
    input logic [DW-1:0] y_o,
    input logic [DW:0]   c_o,
    input logic          ctype_o,
    input logic          res_vld_o
);
    logic [DW:0] c_mag;
    logic [DW:0] y_bound;

    // Magnitude of chroma and the bound 2*y+1 it may not exceed.
    always_comb begin
        c_mag   = c_o[DW] ? (~c_o + 1'b1) : c_o;
        y_bound = {y_o, 1'b1};
    end

    AST_RESULT_HAS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |-> $past(pix_vld_i, 2)); // R6
    AST_NO_ADJACENT_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |=> !res_vld_o); // R5
    AST_NO_RESULT_AFTER_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_i |=> ##1 !res_vld_o); // R7
    AST_HOLD_Y: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld_o |-> $stable(y_o)); // R8
    AST_HOLD_C: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld_o |-> ($stable(c_o) && $stable(ctype_o))); // R8
    AST_CHROMA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |-> (c_mag <= y_bound)); // R3
endmodule

bind mosaic_yc_sep yc_sep_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_vld_i    (pix_vld_i),
    .line_start_i (line_start_i),
    .y_o          (y_o),
    .c_o          (c_o),
    .ctype_o      (ctype_o),
    .res_vld_o    (res_vld_o)
);

// File: tb/sim_mosaic_yc_sep.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them when the design raises its result strobe.
module sim_mosaic_yc_sep;
    localparam int DW       = 10;
    localparam int CLK_NS   = 10;
    localparam int MAXV     = (1 << DW) - 1;
    localparam int WD_LIMIT = 20000;

    typedef struct {
        int  y;
        int  c;
        int  ct;
        int  cyc;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] pix_i = '0;
    logic          pix_vld_i = 1'b0;
    logic          line_start_i = 1'b0;
    logic          field_i = 1'b0;
    logic          line_par_i = 1'b0;
    logic [DW-1:0] y_o;
    logic [DW:0]   c_o;
    logic          ctype_o;
    logic          res_vld_o;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   done = 0;
    bit   seen_result = 0;
    exp_t sb[$];
    int   last_y, last_c, last_t;

    mosaic_yc_sep #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .pix_vld_i(pix_vld_i),
        .line_start_i(line_start_i), .field_i(field_i), .line_par_i(line_par_i),
        .y_o(y_o), .c_o(c_o), .ctype_o(ctype_o), .res_vld_o(res_vld_o)
    );

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sample_val(int mode, int seed, int i);
        int v;
        if (mode == 1) begin
            case (i % 8)
                0, 1, 3, 4: v = MAXV;
                default:    v = 0;
            endcase
        end else begin
            v = (seed * 37 + i * 113 + (i * i) * 7) % (MAXV + 1);
        end
        return v;
    endfunction

    // Drive one line; push an expected result for every completed pair.
    task automatic drive_line(input bit fld, input bit par, input int n,
                              input bit gaps, input bit ls_with_pix,
                              input int mode, input int seed);
        int first_v;
        @(negedge clk);
        field_i      = fld;
        line_par_i   = par;
        line_start_i = 1'b1;
        if (!ls_with_pix) begin
            pix_vld_i = 1'b0;
            @(negedge clk);
            line_start_i = 1'b0;
        end
        first_v = 0;
        for (int i = 0; i < n; i++) begin
            int v;
            v = sample_val(mode, seed, i);
            if (i > 0 || !ls_with_pix) begin
                if (i > 0) @(negedge clk);
                line_start_i = 1'b0;
                if (gaps && (i % 3 == 1)) begin
                    pix_vld_i = 1'b0;
                    @(negedge clk);
                end
            end
            pix_i     = v[DW-1:0];
            pix_vld_i = 1'b1;
            if (i % 2 == 0) begin
                first_v = v;
            end else begin
                exp_t e;
                e.y   = (first_v + v) / 2;
                e.c   = v - first_v;
                e.ct  = int'(fld ^ par);
                e.cyc = cyc + 2;
                sb.push_back(e);
            end
        end
        @(negedge clk);
        pix_vld_i    = 1'b0;
        line_start_i = 1'b0;
    endtask

    // Monitor: compare results against the scoreboard, check holding.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_vld_o) begin
                int cy;
                cy = $signed(c_o);
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R5 unexpected result y=%0d c=%0d expected none", y_o, cy);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (int'(y_o) != e.y) begin
                        errors++;
                        $display("FAIL R2 y actual %0d expected %0d", y_o, e.y);
                    end
                    if (cy != e.c) begin
                        errors++;
                        $display("FAIL R3 chroma actual %0d expected %0d", cy, e.c);
                    end
                    if (int'(ctype_o) != e.ct) begin
                        errors++;
                        $display("FAIL R4 ctype actual %0d expected %0d", ctype_o, e.ct);
                    end
                    if (cyc != e.cyc) begin
                        errors++;
                        $display("FAIL R6 result cycle actual %0d expected %0d", cyc, e.cyc);
                    end
                end
                seen_result = 1;
                last_y = int'(y_o);
                last_c = cy;
                last_t = int'(ctype_o);
            end else if (seen_result) begin
                checks++;
                if (int'(y_o) != last_y || $signed(c_o) != last_c || int'(ctype_o) != last_t) begin
                    errors++;
                    $display("FAIL R8 held y/c/t actual %0d/%0d/%0d expected %0d/%0d/%0d",
                             y_o, $signed(c_o), ctype_o, last_y, last_c, last_t);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(negedge clk) begin
        if (!done && cyc > WD_LIMIT) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual cycle %0d expected below %0d", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (y_o !== '0 || c_o !== '0 || ctype_o !== 1'b0 || res_vld_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %0d/%0d/%0d/%0d expected 0/0/0/0",
                     y_o, c_o, ctype_o, res_vld_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4: all four field/parity combinations
        drive_line(1'b0, 1'b0, 8, 1'b0, 1'b0, 0, 1);
        drive_line(1'b0, 1'b1, 8, 1'b0, 1'b1, 0, 2);
        drive_line(1'b1, 1'b0, 8, 1'b0, 1'b0, 0, 3);
        drive_line(1'b1, 1'b1, 8, 1'b0, 1'b1, 0, 4);
        // R5: idle gaps inside a line
        drive_line(1'b0, 1'b1, 12, 1'b1, 1'b0, 0, 5);
        // R7: odd trailing sample dropped, then a line starting with a sample
        drive_line(1'b1, 1'b0, 5, 1'b0, 1'b1, 0, 6);
        drive_line(1'b1, 1'b1, 7, 1'b1, 1'b1, 0, 7);
        drive_line(1'b0, 1'b0, 6, 1'b0, 1'b1, 0, 8);
        // R9: extremes
        drive_line(1'b0, 1'b0, 8, 1'b0, 1'b0, 1, 0);
        drive_line(1'b1, 1'b0, 8, 1'b1, 1'b1, 1, 0);

        repeat (6) @(negedge clk);
        // R5 R7: every expected result arrived, nothing extra pending
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R5 pending results actual %0d expected 0", sb.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule